// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This unit watches a set of general-purpose pins, arranged as banks of equal width, for level changes. Software supplies, per pin, a direction bit and separate enables for rising and falling detection. When an enabled edge arrives on a pin that is configured as an input, the pin's status bit is set. The bit stays set until software writes a 1 to it through a bank-addressed clear port. The full status vector is visible on an output so that a register block can return it on a read.

The status vector is reduced to three interrupt lines. Pin 0 and pin 1 of bank 0 each drive a private line. Every other status bit feeds one shared line. While the processor reports that it is halted, a level change on an input pin whose bit is set in a fixed per-bank wake mask produces a one-cycle wake request. Pin levels arrive already synchronised to the clock. What the processor does with a wake request is decided outside this unit.

Edges are found by comparing each cycle's sampled pin levels with a registered copy of the previous cycle's levels. That copy is updated every cycle, whether or not an edge was captured. Status, interrupt and wake outputs are all registered, so they change on the clock edge that samples the causing input.

Top module: `gpio_edge_irq_unit`

## Requirements
- R1: A status bit is set on a 0-to-1 change of its pin only when that pin's rising enable is 1 and its direction bit is 0 (input). A direction bit of 1 means output and blocks capture.
- R2: A status bit is set on a 1-to-0 change of its pin only when that pin's falling enable is 1 and its direction bit is 0.
- R3: Status bits are sticky. A clear write with `clr_we`=1 clears, in the bank numbered `clr_bank`, each bit whose `clr_mask` bit is 1. Bits whose mask bit is 0, and all bits in other banks, are left unchanged.
- R4: If a clear write and a newly detected edge hit the same status bit in the same cycle, the bit ends up set.
- R5: `irq_pin0` is 1 exactly while status bit 0 (bank 0, pin 0) is set.
- R6: `irq_pin1` is 1 exactly while status bit 1 (bank 0, pin 1) is set.
- R7: `irq_shared` is 1 exactly while any status bit other than bits 0 and 1 is set, in any bank.
- R8: `wake_req` is 1 for the cycle after a cycle in which `cpu_halted` is 1 and a wake-capable input pin changed level. It is 0 if the processor is not halted, or if the pin is an output.
- R9: The wake-capable bits for banks 0, 1, 2 and 3 are 32'h8003FE1B, 32'h002001FC, 32'hEC080000 and 32'h0012007F. Status bit b of bank k is vector bit k*32+b.
- R10: The stored previous level follows the pin on every cycle, including changes that were not captured. Enabling detection later therefore does not report a change that happened earlier.
- R11: After reset the status vector, all three interrupt lines and `wake_req` are 0, and the stored previous levels are 0.
- R12: A pin change sampled at one clock edge is visible on `edge_status` and on the interrupt lines right after that same edge, with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_level | input | NUM_PINS | Synchronised pin levels |
| pin_is_out | input | NUM_PINS | Direction per pin, 1 = output |
| rise_en | input | NUM_PINS | Rising-edge detect enables |
| fall_en | input | NUM_PINS | Falling-edge detect enables |
| clr_we | input | 1 | Status clear write strobe |
| clr_bank | input | IDX_W | Bank addressed by the clear write |
| clr_mask | input | BANK_W | Write-one-to-clear mask for that bank |
| cpu_halted | input | 1 | Processor halted flag |
| edge_status | output | NUM_PINS | Sticky edge status vector |
| irq_pin0 | output | 1 | Interrupt for bank 0 pin 0 |
| irq_pin1 | output | 1 | Interrupt for bank 0 pin 1 |
| irq_shared | output | 1 | Interrupt for all other pins |
| wake_req | output | 1 | One-cycle wake request |

## Verification
The bench uses the default parameters: four banks of 32 pins, with the wake mask built from the four fixed words. With these values every bank can be reached, including bank 3 at the top of the vector. This covers the routing of bank 0 pins 0 and 1 against pins in higher banks on the shared line, clears aimed at the wrong bank, and wake-mask bits checked in both the lowest and the highest bank. Each scenario starts from a fresh reset, so the previous-level register begins at zero every time.

// File: rtl/gpio_edge_pkg.sv
`timescale 1ns/1ps
package gpio_edge_pkg;

  localparam int DEF_BANKS  = 4;
  localparam int DEF_BANK_W = 32;

  // Wake-capable pins, bank 3 in the top word down to bank 0 in the bottom word
  localparam logic [DEF_BANKS*DEF_BANK_W-1:0] DEF_WAKE_MASK =
    {32'h0012_007F, 32'hEC08_0000, 32'h0020_01FC, 32'h8003_FE1B};

  typedef struct packed {
    logic line0;
    logic line1;
    logic shared;
  } irq_bundle_t;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/gpio_edge_bank.sv
`timescale 1ns/1ps
module gpio_edge_bank #(
  parameter int                BANK_W    = 32,
  parameter int                BANK_ID   = 0,
  parameter int                IDX_W     = 2,
  parameter logic [BANK_W-1:0] WAKE_BITS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] level,
  input  logic [BANK_W-1:0] is_out,
  input  logic [BANK_W-1:0] rise_en,
  input  logic [BANK_W-1:0] fall_en,
  input  logic              clr_we,
  input  logic [IDX_W-1:0]  clr_bank,
  input  logic [BANK_W-1:0] clr_mask,
  output logic [BANK_W-1:0] status_nxt,
  output logic [BANK_W-1:0] status_q,
  output logic [BANK_W-1:0] edge_hit,
  output logic              wake_hit
);

  // Rising edge: the pin is high now, was low before, detection is enabled and the pin is an input
  function automatic logic [BANK_W-1:0] rise_fn(
    input logic [BANK_W-1:0] cur, input logic [BANK_W-1:0] prv,
    input logic [BANK_W-1:0] en,  input logic [BANK_W-1:0] out);
    return cur & ~prv & en & ~out;
  endfunction

  function automatic logic [BANK_W-1:0] fall_fn(
    input logic [BANK_W-1:0] cur, input logic [BANK_W-1:0] prv,
    input logic [BANK_W-1:0] en,  input logic [BANK_W-1:0] out);
    return ~cur & prv & en & ~out;
  endfunction

  // The clear is applied first and new hits are ORed in after it, so a new edge wins
  function automatic logic [BANK_W-1:0] merge_fn(
    input logic [BANK_W-1:0] st, input logic [BANK_W-1:0] clr,
    input logic [BANK_W-1:0] hits);
    return (st & ~clr) | hits;
  endfunction

  logic [BANK_W-1:0] prev_q;
  logic [BANK_W-1:0] clr_vec;
  logic [BANK_W-1:0] change;

  assign clr_vec    = (clr_we && (clr_bank == IDX_W'(BANK_ID))) ? clr_mask : '0;
  assign edge_hit   = rise_fn(level, prev_q, rise_en, is_out)
                    | fall_fn(level, prev_q, fall_en, is_out);
  assign status_nxt = merge_fn(status_q, clr_vec, edge_hit);
  assign change     = level ^ prev_q;
  assign wake_hit   = |(change & ~is_out & WAKE_BITS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= level;
      status_q <= status_nxt;
    end
  end

endmodule

// File: rtl/gpio_irq_route.sv
`timescale 1ns/1ps
module gpio_irq_route
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] status_nxt,
  output irq_bundle_t         irq_q
);

  localparam int REST_W = NUM_PINS - 2;

  function automatic logic any_rest(input logic [REST_W-1:0] v);
    return |v;
  endfunction

  irq_bundle_t irq_d;

  always_comb begin
    irq_d.line0  = status_nxt[0];
    irq_d.line1  = status_nxt[1];
    irq_d.shared = any_rest(status_nxt[NUM_PINS-1:2]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

endmodule

// File: rtl/gpio_wake_gen.sv
`timescale 1ns/1ps
module gpio_wake_gen #(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] bank_hit,
  input  logic                 cpu_halted,
  output logic                 wake_req
);

  logic wake_d;
  assign wake_d = cpu_halted & (|bank_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) wake_req <= 1'b0;
    else        wake_req <= wake_d;
  end

endmodule

// File: rtl/gpio_edge_irq_unit.sv
`timescale 1ns/1ps
module gpio_edge_irq_unit
  import gpio_edge_pkg::*;
#(
  parameter  int NUM_BANKS = gpio_edge_pkg::DEF_BANKS,
  parameter  int BANK_W    = gpio_edge_pkg::DEF_BANK_W,
  localparam int NUM_PINS  = NUM_BANKS * BANK_W,
  localparam int IDX_W     = gpio_edge_pkg::idx_width(NUM_BANKS),
  parameter  logic [NUM_PINS-1:0] WAKE_MASK = NUM_PINS'(gpio_edge_pkg::DEF_WAKE_MASK)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_level,
  input  logic [NUM_PINS-1:0] pin_is_out,
  input  logic [NUM_PINS-1:0] rise_en,
  input  logic [NUM_PINS-1:0] fall_en,
  input  logic                clr_we,
  input  logic [IDX_W-1:0]    clr_bank,
  input  logic [BANK_W-1:0]   clr_mask,
  input  logic                cpu_halted,
  output logic [NUM_PINS-1:0] edge_status,
  output logic                irq_pin0,
  output logic                irq_pin1,
  output logic                irq_shared,
  output logic                wake_req
);

  logic [NUM_PINS-1:0]  status_nxt;
  logic [NUM_PINS-1:0]  edge_hit;
  logic [NUM_BANKS-1:0] bank_wake_hit;
  irq_bundle_t          irq_q;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    gpio_edge_bank #(
      .BANK_W    (BANK_W),
      .BANK_ID   (g),
      .IDX_W     (IDX_W),
      .WAKE_BITS (WAKE_MASK[g*BANK_W +: BANK_W])
    ) bank_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .level      (pin_level [g*BANK_W +: BANK_W]),
      .is_out     (pin_is_out[g*BANK_W +: BANK_W]),
      .rise_en    (rise_en   [g*BANK_W +: BANK_W]),
      .fall_en    (fall_en   [g*BANK_W +: BANK_W]),
      .clr_we     (clr_we),
      .clr_bank   (clr_bank),
      .clr_mask   (clr_mask),
      .status_nxt (status_nxt [g*BANK_W +: BANK_W]),
      .status_q   (edge_status[g*BANK_W +: BANK_W]),
      .edge_hit   (edge_hit   [g*BANK_W +: BANK_W]),
      .wake_hit   (bank_wake_hit[g])
    );
  end

  gpio_irq_route #(.NUM_PINS(NUM_PINS)) route_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .status_nxt (status_nxt),
    .irq_q      (irq_q)
  );

  assign irq_pin0   = irq_q.line0;
  assign irq_pin1   = irq_q.line1;
  assign irq_shared = irq_q.shared;

  gpio_wake_gen #(.NUM_BANKS(NUM_BANKS)) wake_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_hit   (bank_wake_hit),
    .cpu_halted (cpu_halted),
    .wake_req   (wake_req)
  );

endmodule

// File: rtl/gpio_edge_irq_sva.sv
`timescale 1ns/1ps
module gpio_edge_irq_sva #(
  parameter int NUM_PINS = 128
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] pin_is_out,
  input logic [NUM_PINS-1:0] rise_en,
  input logic [NUM_PINS-1:0] fall_en,
  input logic                clr_we,
  input logic                cpu_halted,
  input logic [NUM_PINS-1:0] edge_status,
  input logic [NUM_PINS-1:0] edge_hit,
  input logic                irq_pin0,
  input logic                irq_pin1,
  input logic                irq_shared,
  input logic                wake_req
);

  // R1: a bit can only become set if its pin was an input in the sampling cycle
  p_input_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_status & ~$past(edge_status) & $past(pin_is_out)) == '0));

  // R2: a bit can only become set if one of its detect enables was on
  p_enable_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_status & ~$past(edge_status) & ~($past(rise_en) | $past(fall_en))) == '0));

  // R3: without a clear write no status bit is lost
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_we) |-> (($past(edge_status) & ~edge_status) == '0));

  // R4: every detected hit shows up set in the next cycle, even if a clear hit it too
  p_edge_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(edge_hit) & ~edge_status) == '0));

  // R5
  p_irq0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pin0 == edge_status[0]);

  // R6
  p_irq1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pin1 == edge_status[1]);

  // R7
  p_shared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_shared == (|edge_status[NUM_PINS-1:2]));

  // R8: a wake request always follows a halted cycle
  p_wake_halted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(cpu_halted));

endmodule

bind gpio_edge_irq_unit gpio_edge_irq_sva #(.NUM_PINS(NUM_PINS)) sva_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .pin_is_out  (pin_is_out),
  .rise_en     (rise_en),
  .fall_en     (fall_en),
  .clr_we      (clr_we),
  .cpu_halted  (cpu_halted),
  .edge_status (edge_status),
  .edge_hit    (edge_hit),
  .irq_pin0    (irq_pin0),
  .irq_pin1    (irq_pin1),
  .irq_shared  (irq_shared),
  .wake_req    (wake_req)
);

// File: tb/gpio_edge_irq_unit_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_irq_unit_tb_top;

  localparam int NB = 4;
  localparam int BW = 32;
  localparam int NP = NB * BW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pin_level, pin_is_out, rise_en, fall_en;
  logic          clr_we;
  logic [1:0]    clr_bank;
  logic [BW-1:0] clr_mask;
  logic          cpu_halted;
  logic [NP-1:0] edge_status;
  logic          irq_pin0, irq_pin1, irq_shared, wake_req;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_edge_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .pin_is_out(pin_is_out),
    .rise_en(rise_en), .fall_en(fall_en), .clr_we(clr_we), .clr_bank(clr_bank),
    .clr_mask(clr_mask), .cpu_halted(cpu_halted), .edge_status(edge_status),
    .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_shared(irq_shared),
    .wake_req(wake_req)
  );

  // Wake masks written bitwise, bank 0 first
  function automatic bit wake_cap(input int bank, input int pin);
    logic [31:0] m;
    case (bank)
      0: m = 32'b1000_0000_0000_0011_1111_1110_0001_1011;
      1: m = 32'b0000_0000_0010_0000_0000_0001_1111_1100;
      2: m = 32'b1110_1100_0000_1000_0000_0000_0000_0000;
      default: m = 32'b0000_0000_0001_0010_0000_0000_0111_1111;
    endcase
    return m[pin];
  endfunction

  function automatic int pidx(input int bank, input int pin);
    return bank * BW + pin;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [NP-1:0] act,
                     input logic [NP-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    pin_level = '0; pin_is_out = '0; rise_en = '0; fall_en = '0;
    clr_we = 1'b0; clr_bank = '0; clr_mask = '0; cpu_halted = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_reset();
    do_reset();
    chk(edge_status == '0, "R11 status", edge_status, '0);
    chk({irq_pin0, irq_pin1, irq_shared, wake_req} == 4'b0, "R11 outputs",
        NP'({irq_pin0, irq_pin1, irq_shared, wake_req}), '0);
  endtask

  task automatic t_rise();
    logic [NP-1:0] exp = '0;
    do_reset();
    rise_en = '1;
    pin_level[pidx(0,5)] = 1'b1;
    exp[pidx(0,5)] = 1'b1;
    step();
    chk(edge_status == exp, "R1 rising captured", edge_status, exp);
    chk(irq_shared == 1'b1, "R12 shared same edge", NP'(irq_shared), NP'(1));
    pin_is_out[pidx(1,3)] = 1'b1;
    pin_level[pidx(1,3)] = 1'b1;
    rise_en[pidx(2,7)] = 1'b0;
    pin_level[pidx(2,7)] = 1'b1;
    step();
    chk(edge_status == exp, "R1 output or disabled ignored", edge_status, exp);
    pin_level[pidx(0,5)] = 1'b0;
    step();
    chk(edge_status == exp, "R1 falling not captured by rise enable", edge_status, exp);
  endtask

  task automatic t_fall();
    logic [NP-1:0] exp = '0;
    do_reset();
    fall_en = '1;
    pin_level[pidx(3,9)] = 1'b1;
    step();
    chk(edge_status == '0, "R2 rising ignored", edge_status, '0);
    pin_level[pidx(3,9)] = 1'b0;
    exp[pidx(3,9)] = 1'b1;
    step();
    chk(edge_status == exp, "R2 falling captured", edge_status, exp);
  endtask

  task automatic t_clear();
    logic [NP-1:0] exp = '0;
    do_reset();
    rise_en = '1;
    pin_level[pidx(0,5)] = 1'b1; pin_level[pidx(0,9)] = 1'b1;
    exp[pidx(0,5)] = 1'b1; exp[pidx(0,9)] = 1'b1;
    step();
    pin_level[pidx(0,5)] = 1'b0;
    step();
    chk(edge_status == exp, "R3 sticky after pin drops", edge_status, exp);
    clr_we = 1'b1; clr_bank = 2'd1; clr_mask = 32'h0000_0220;
    step();
    chk(edge_status == exp, "R3 other bank unaffected", edge_status, exp);
    clr_bank = 2'd0; clr_mask = 32'h0000_0020;
    exp[pidx(0,5)] = 1'b0;
    step();
    clr_we = 1'b0;
    chk(edge_status == exp, "R3 one cleared, zero bit kept", edge_status, exp);
  endtask

  task automatic t_race();
    logic [NP-1:0] exp = '0;
    do_reset();
    rise_en = '1;
    pin_level[pidx(2,4)] = 1'b1;
    step();
    pin_level[pidx(2,4)] = 1'b0;
    step();
    pin_level[pidx(2,4)] = 1'b1;
    clr_we = 1'b1; clr_bank = 2'd2; clr_mask = 32'h0000_0010;
    exp[pidx(2,4)] = 1'b1;
    step();
    clr_we = 1'b0;
    chk(edge_status == exp, "R4 edge wins over clear", edge_status, exp);
  endtask

  task automatic t_irq();
    do_reset();
    rise_en = '1;
    pin_level[0] = 1'b1;
    step();
    chk({irq_pin0, irq_pin1, irq_shared} == 3'b100, "R5 pin0 line",
        NP'({irq_pin0, irq_pin1, irq_shared}), NP'(3'b100));
    clr_we = 1'b1; clr_bank = 2'd0; clr_mask = 32'h1;
    step();
    clr_we = 1'b0;
    chk(irq_pin0 == 1'b0, "R5 dropped after clear", NP'(irq_pin0), '0);
    pin_level[1] = 1'b1;
    step();
    chk({irq_pin0, irq_pin1, irq_shared} == 3'b010, "R6 pin1 line",
        NP'({irq_pin0, irq_pin1, irq_shared}), NP'(3'b010));
    pin_level[pidx(3,31)] = 1'b1;
    step();
    chk({irq_pin0, irq_pin1, irq_shared} == 3'b011, "R7 bank3 shared",
        NP'({irq_pin0, irq_pin1, irq_shared}), NP'(3'b011));
  endtask

  task automatic t_level();
    do_reset();
    pin_level[pidx(1,12)] = 1'b1;
    step();
    rise_en = '1;
    step(); step();
    chk(edge_status == '0, "R10 earlier change not reported", edge_status, '0);
  endtask

  task automatic t_wake();
    do_reset();
    cpu_halted = 1'b1;
    pin_level[pidx(0,0)] = 1'b1;
    step();
    chk(wake_req == wake_cap(0,0), "R8 wake on halted change", NP'(wake_req), NP'(1));
    step();
    chk(wake_req == 1'b0, "R8 single pulse", NP'(wake_req), '0);
    pin_level[pidx(0,2)] = 1'b1;
    step();
    chk(wake_req == wake_cap(0,2), "R9 bank0 pin2 not wake-capable", NP'(wake_req), '0);
    pin_level[pidx(3,20)] = 1'b1;
    step();
    chk(wake_req == wake_cap(3,20), "R9 bank3 pin20 wake-capable", NP'(wake_req), NP'(1));
    pin_level[pidx(2,31)] = 1'b1;
    step();
    chk(wake_req == wake_cap(2,31), "R9 bank2 pin31 wake-capable", NP'(wake_req), NP'(1));
    cpu_halted = 1'b0;
    pin_level[pidx(0,0)] = 1'b0;
    step();
    chk(wake_req == 1'b0, "R8 not halted", NP'(wake_req), '0);
    cpu_halted = 1'b1;
    pin_is_out[pidx(0,1)] = 1'b1;
    pin_level[pidx(0,1)] = 1'b1;
    step();
    chk(wake_req == 1'b0, "R8 output pin ignored", NP'(wake_req), '0);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_rise();
    t_fall();
    t_clear();
    t_race();
    t_irq();
    t_level();
    t_wake();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule